// File: doc/BRIEF.md
# SPI Command Engine with Prefix Bytes

This block is the master end of a four-signal serial link shared by eight peripherals. It carries out one command at a time. A command is either a write or a read. It has an active-high select mask, a bit-order flag, a prefix of zero, one or two bytes taken from a 16-bit value, and a body length of up to 64 bytes. The link uses a shared clock, a master-to-peripheral data line, a peripheral-to-master data line and eight active-low enables.

A write sends the prefix bytes and then the body bytes from a local 64-byte buffer, starting at address 0. A read sends the prefix bytes and then shifts in the body from the single selected peripheral, storing byte k at buffer address k. The host fills and reads the buffer through a simple port while the engine is idle.

The engine checks every command before it starts. A command that cannot be carried out is refused with a one-cycle error pulse, and the link stays quiet.

Top module: `spi_hdr_engine`

## Requirements
- R1: The link runs in mode 0. `sclk_o` idles low. Each half-period of `sclk_o` lasts HALF_DIV system clocks. `mosi_o` changes only together with a falling edge of `sclk_o` or at the start and end of a transaction. `miso_i` is sampled on the system clock edge that raises `sclk_o`.
- R2: When `lsb_first_i` is 1, each byte is sent and received bit 0 first. When it is 0, each byte goes bit 7 first.
- R3: `hdr_cnt_i` sets the prefix length: 00 means none, 01 means one byte and 10 means two bytes. One prefix byte is `hdr_i[7:0]`. With two prefix bytes, MSB-first order sends `hdr_i[15:8]` and then `hdr_i[7:0]`, and LSB-first order sends `hdr_i[7:0]` and then `hdr_i[15:8]`.
- R4: A write sends the prefix bytes and then buffer bytes 0 to `len_i`-1, in that order.
- R5: A read sends the prefix bytes and holds `mosi_o` low during the body. It stores received body byte k at buffer address k, where the host port can then read it.
- R6: During a transaction, `sel_no` equals the inverse of the latched mask, and at all other times it is all ones. The enables become active one half-period before the first rising clock edge. They are released one half-period after the last falling clock edge, and they do not change in between.
- R7: A read whose mask does not have exactly one bit set is refused: `err_o` pulses for one cycle, `busy_o` stays low and no link signal moves.
- R8: A command with `hdr_cnt_i` = 11 or with `len_i` above 64 is refused in the same way as in R7.
- R9: A zero-length body is accepted. The transaction ends after the prefix. With no prefix either, the enables are active for 2*HALF_DIV cycles and `sclk_o` never rises.
- R10: `busy_o` is high from the cycle after an accepted `start_i` until the enables are released. `done_o` pulses for one cycle right after `busy_o` falls. A `start_i` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, one cycle |
| rd_i | input | 1 | 1 = read command, 0 = write command |
| lsb_first_i | input | 1 | Bit order: 1 = bit 0 first |
| hdr_cnt_i | input | 2 | Prefix byte count code |
| hdr_i | input | 16 | Prefix value |
| len_i | input | 7 | Body length in bytes |
| sel_i | input | 8 | Peripheral select mask, active high |
| host_we_i | input | 1 | Buffer write strobe (ignored while busy) |
| host_addr_i | input | 6 | Buffer address |
| host_wdata_i | input | 8 | Buffer write data |
| host_rdata_o | output | 8 | Buffer read data at `host_addr_i` |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Refusal pulse |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Master-to-peripheral data |
| miso_i | input | 1 | Peripheral-to-master data |
| sel_no | output | 8 | Peripheral enables, active low |

## Verification
The assertions check on every cycle the properties that need no knowledge of the data:
- the idle state of the link;
- enables held steady through a transaction;
- exactly one enable active during a read;
- `mosi_o` steady while `sclk_o` is high;
- no clock during an empty transaction;
- the timing of the refusal and completion pulses;
- the bounds of the tick counter.

Only the bench's scenarios can show the following:
- the bit and byte order of the prefix and body;
- the exact half-period spacing of every edge;
- the placement of captured bytes in the buffer;
- that a second strobe while busy leaves the running transfer untouched.

// File: rtl/spi_hdr_pkg.sv
package spi_hdr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL
  } eng_st_e;

  localparam int HDR_W   = 16;
  localparam int BYTE_W  = 8;
  localparam logic [1:0] HC_BAD = 2'b11;

  function automatic logic hc_valid(logic [1:0] hc);
    return hc != HC_BAD;
  endfunction
endpackage

// File: rtl/spi_hdr_tick.sv
module spi_hdr_tick #(
  parameter  int HALF_DIV = 2,
  localparam int CW = $clog2(HALF_DIV + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(HALF_DIV)); // R1
  AST_TICK_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0); // R1
endmodule

// File: rtl/spi_hdr_buf.sv
module spi_hdr_buf #(
  parameter  int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [7:0]    host_wdata_i,
  output logic [7:0]    host_rdata_o,
  input  logic          eng_we_i,
  input  logic [AW-1:0] eng_addr_i,
  input  logic [7:0]    eng_wdata_i,
  output logic [7:0]    eng_rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (eng_we_i)       mem_q[eng_addr_i]  <= eng_wdata_i;
    else if (host_we_i) mem_q[host_addr_i] <= host_wdata_i;
  end

  assign host_rdata_o = mem_q[host_addr_i];
  assign eng_rdata_o  = mem_q[eng_addr_i];
endmodule

// File: rtl/spi_hdr_bits.sv
module spi_hdr_bits import spi_hdr_pkg::*; #(
  parameter  int BW = 7,
  parameter  int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          rd_i,
  input  logic          lsb_i,
  input  logic [1:0]    hn_i,
  input  logic [HDR_W-1:0] hdr_i,
  input  logic [BW-1:0] byte_idx_i,
  input  logic [2:0]    bit_idx_i,
  input  logic [7:0]    body_i,
  input  logic          sample_i,
  input  logic          miso_i,
  output logic          mosi_o,
  output logic          in_body_o,
  output logic [AW-1:0] body_addr_o,
  output logic [7:0]    rx_next_o
);
  logic       hi_sel;
  logic [7:0] hdr_byte, cur_byte, rx_q;
  logic [2:0] bit_pos;

  assign in_body_o   = byte_idx_i >= BW'(hn_i);
  assign body_addr_o = AW'(byte_idx_i - BW'(hn_i));

  // two-byte prefix: high byte leads in MSB order, low byte leads in LSB order
  assign hi_sel   = (hn_i == 2'd2) && ((byte_idx_i == '0) != lsb_i);
  assign hdr_byte = hi_sel ? hdr_i[15:8] : hdr_i[7:0];
  assign cur_byte = in_body_o ? (rd_i ? 8'h00 : body_i) : hdr_byte;
  assign bit_pos  = lsb_i ? bit_idx_i : 3'd7 - bit_idx_i;
  assign mosi_o   = act_i & cur_byte[bit_pos];

  assign rx_next_o = lsb_i ? {miso_i, rx_q[7:1]} : {rx_q[6:0], miso_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_q <= '0;
    else if (sample_i) rx_q <= rx_next_o;
  end
endmodule

// File: rtl/spi_hdr_engine.sv
module spi_hdr_engine import spi_hdr_pkg::*; #(
  parameter  int HALF_DIV = 2,
  parameter  int NSEL     = 8,
  parameter  int MAX_LEN  = 64,
  localparam int LEN_W = $clog2(MAX_LEN + 1),
  localparam int AW    = $clog2(MAX_LEN),
  localparam int BW    = $clog2(MAX_LEN + 3)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic             lsb_first_i,
  input  logic [1:0]       hdr_cnt_i,
  input  logic [HDR_W-1:0] hdr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [NSEL-1:0]  sel_i,
  input  logic             host_we_i,
  input  logic [AW-1:0]    host_addr_i,
  input  logic [7:0]       host_wdata_i,
  output logic [7:0]       host_rdata_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic [NSEL-1:0]  sel_no
);
  eng_st_e          st_q;
  logic             rd_q, lsb_q, done_q, err_q;
  logic [1:0]       hn_q;
  logic [HDR_W-1:0] hdr_q;
  logic [NSEL-1:0]  sel_q;
  logic [BW-1:0]    nbytes_q, byte_idx_q;
  logic [2:0]       bit_idx_q;

  logic tick, cmd_ok, sample, last_bit, act, in_body, eng_we;
  logic [AW-1:0] body_addr;
  logic [7:0]    body_byte, rx_next;

  assign cmd_ok = hc_valid(hdr_cnt_i)
               && (len_i <= LEN_W'(MAX_LEN))
               && (!rd_i || ($countones(sel_i) == 1));

  assign busy_o = (st_q != ST_IDLE);
  assign sclk_o = (st_q == ST_HIGH);
  assign sel_no = busy_o ? ~sel_q : '1;
  assign done_o = done_q;
  assign err_o  = err_q;

  assign act      = (st_q == ST_LEAD || st_q == ST_HIGH || st_q == ST_LOW) && (nbytes_q != '0);
  assign sample   = tick && act && (st_q != ST_HIGH);
  assign last_bit = (bit_idx_q == 3'd7) && (byte_idx_q == nbytes_q - BW'(1));
  assign eng_we   = sample && rd_q && in_body && (bit_idx_q == 3'd7);

  spi_hdr_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  spi_hdr_buf #(.DEPTH(MAX_LEN)) u_buf (
    .clk_i        (clk_i),
    .host_we_i    (host_we_i && !busy_o),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .eng_we_i     (eng_we),
    .eng_addr_i   (body_addr),
    .eng_wdata_i  (rx_next),
    .eng_rdata_o  (body_byte)
  );

  spi_hdr_bits #(.BW(BW), .AW(AW)) u_bits (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act),
    .rd_i        (rd_q),
    .lsb_i       (lsb_q),
    .hn_i        (hn_q),
    .hdr_i       (hdr_q),
    .byte_idx_i  (byte_idx_q),
    .bit_idx_i   (bit_idx_q),
    .body_i      (body_byte),
    .sample_i    (sample && in_body),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .in_body_o   (in_body),
    .body_addr_o (body_addr),
    .rx_next_o   (rx_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      rd_q       <= 1'b0;
      lsb_q      <= 1'b0;
      hn_q       <= '0;
      hdr_q      <= '0;
      sel_q      <= '0;
      nbytes_q   <= '0;
      byte_idx_q <= '0;
      bit_idx_q  <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (cmd_ok) begin
            st_q       <= ST_LEAD;
            rd_q       <= rd_i;
            lsb_q      <= lsb_first_i;
            hn_q       <= hdr_cnt_i;
            hdr_q      <= hdr_i;
            sel_q      <= sel_i;
            nbytes_q   <= BW'(hdr_cnt_i) + BW'(len_i);
            byte_idx_q <= '0;
            bit_idx_q  <= '0;
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_LEAD: if (tick) st_q <= (nbytes_q == '0) ? ST_TAIL : ST_HIGH;
        ST_HIGH: if (tick) begin
          if (last_bit) begin
            st_q <= ST_TAIL;
          end else begin
            st_q      <= ST_LOW;
            bit_idx_q <= bit_idx_q + 3'd1;
            if (bit_idx_q == 3'd7) byte_idx_q <= byte_idx_q + BW'(1);
          end
        end
        ST_LOW:  if (tick) st_q <= ST_HIGH;
        ST_TAIL: if (tick) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && !mosi_o && sel_no == '1)); // R6
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(sel_no)); // R6
  AST_MOSI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R1
  AST_READ_ONE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_q) |-> ($countones(~sel_no) == 1)); // R7
  AST_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !cmd_ok) |=> (err_o && !busy_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R10
  AST_EMPTY_NO_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && nbytes_q == '0) |-> !sclk_o); // R9
  AST_CAPTURE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_we |-> (busy_o && rd_q && sclk_o == 1'b0)); // R5
endmodule

// File: tb/spi_hdr_engine_tb_top.sv
module spi_hdr_engine_tb_top;
  localparam int HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, rd = 0, lsb = 0, miso = 0, hwe = 0;
  logic [1:0]  hc = 0;
  logic [15:0] hdr = 0;
  logic [6:0]  len = 0;
  logic [7:0]  sel = 0, hwd = 0, hrd, sel_n;
  logic [5:0]  haddr = 0;
  logic busy, done, err, sclk, mosi;

  always #10 clk = ~clk;

  spi_hdr_engine #(.HALF_DIV(HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_i(rd), .lsb_first_i(lsb),
    .hdr_cnt_i(hc), .hdr_i(hdr), .len_i(len), .sel_i(sel),
    .host_we_i(hwe), .host_addr_i(haddr), .host_wdata_i(hwd), .host_rdata_o(hrd),
    .busy_o(busy), .done_o(done), .err_o(err), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .sel_no(sel_n)
  );

  int checks = 0, fails = 0;
  bit mon_en = 0;
  logic [12:0] exp_q[$];          // {err,done,busy,sel_n[7:0],mosi,sclk}
  logic [7:0]  mirror [64];
  logic [1023:0] pat;
  int rise_cnt = 0;
  bit sclk_prev = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [12:0] vec(bit e, bit d, bit b, logic [7:0] s, bit m, bit c);
    return {e, d, b, s, m, c};
  endfunction

  // cycle-by-cycle comparison against the expected queue
  always @(posedge clk) begin
    #5;
    if (mon_en) begin
      logic [12:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : vec(0, 0, 0, 8'hFF, 0, 0);
      chk("R1 sclk", sclk, e[0]);
      chk("R4 mosi", mosi, e[1]);
      chk("R6 sel_n", sel_n, e[9:2]);
      chk("R10 busy", busy, e[10]);
      chk("R10 done", done, e[11]);
      chk("R8 err", err, e[12]);
    end
  end

  // peripheral: next stream bit after every rising sclk
  always @(posedge clk) begin
    #7;
    if (sclk && !sclk_prev) rise_cnt++;
    sclk_prev = sclk;
    miso = pat[rise_cnt % 1024];
  end

  task automatic push_n(int n, logic [12:0] v);
    for (int i = 0; i < n; i++) exp_q.push_back(v);
  endtask

  task automatic run_cmd(input bit r, input bit l, input logic [1:0] c, input logic [15:0] h,
                         input logic [6:0] n, input logic [7:0] s, input bit poke);
    bit ok, bits[$];
    int hn, nb;
    logic [7:0] byt, cap;
    ok = (c != 2'b11) && (n <= 64) && (!r || $countones(s) == 1);
    @(negedge clk);
    if (ok) begin
      hn = c;
      for (int b = 0; b < hn + n; b++) begin
        if (b < hn) byt = (hn == 1) ? h[7:0] : (((b == 0) != l) ? h[15:8] : h[7:0]);
        else        byt = r ? 8'h00 : mirror[b - hn];
        for (int k = 0; k < 8; k++) bits.push_back(l ? byt[k] : byt[7-k]);
      end
      nb = bits.size();
      if (nb == 0) push_n(2*HALF, vec(0, 0, 1, ~s, 0, 0));
      else begin
        push_n(HALF, vec(0, 0, 1, ~s, bits[0], 0));
        for (int i = 0; i < nb; i++) begin
          push_n(HALF, vec(0, 0, 1, ~s, bits[i], 1));
          if (i < nb - 1) push_n(HALF, vec(0, 0, 1, ~s, bits[i+1], 0));
        end
        push_n(HALF, vec(0, 0, 1, ~s, 0, 0));
      end
      exp_q.push_back(vec(0, 1, 0, 8'hFF, 0, 0));
    end else begin
      exp_q.push_back(vec(1, 0, 0, 8'hFF, 0, 0));
    end
    rd = r; lsb = l; hc = c; hdr = h; len = n; sel = s; start = 1;
    rise_cnt = 0; miso = pat[0];
    @(negedge clk);
    start = 0;
    if (poke) begin                      // R10: strobe while busy must be ignored
      repeat (10) @(negedge clk);
      rd = 1; lsb = ~l; hc = 2'd1; len = 7'd1; sel = 8'h01; start = 1;
      @(negedge clk);
      start = 0;
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
    if (ok && r) begin                   // R5: captured bytes in the buffer
      for (int b = 0; b < n; b++) begin
        for (int k = 0; k < 8; k++) begin
          if (l) cap[k] = pat[8*c + 8*b + k];
          else   cap[7-k] = pat[8*c + 8*b + k];
        end
        mirror[b] = cap;
        haddr = 6'(b);
        #1;
        chk("R5 capture", hrd, cap);
      end
    end
  endtask

  task automatic fill(input int seed);
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      hwe = 1; haddr = 6'(a); hwd = 8'(a * seed + 3); mirror[a] = 8'(a * seed + 3);
    end
    @(negedge clk);
    hwe = 0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) pat[i] = ((i * 29 + 7) % 11) > 4;
    #35;
    chk("R6 reset sel_n", sel_n, 8'hFF);
    chk("R10 reset busy", busy, 0);
    chk("R1 reset sclk", sclk, 0);
    rst_n = 1;
    @(negedge clk);
    mon_en = 1;
    fill(7);
    run_cmd(0, 0, 2'd0, 16'h0000, 7'd2, 8'h10, 0);   // R4 MSB write, no prefix
    run_cmd(0, 1, 2'd1, 16'h5AC3, 7'd1, 8'h15, 0);   // R2 R3 LSB, one prefix byte, multi-select
    run_cmd(0, 0, 2'd2, 16'hB1E4, 7'd0, 8'h02, 0);   // R3 R9 two prefix bytes, empty body
    run_cmd(0, 1, 2'd2, 16'h3C96, 7'd3, 8'h40, 0);   // R2 R3 LSB two prefix bytes
    run_cmd(0, 0, 2'd0, 16'h0000, 7'd0, 8'h80, 0);   // R9 nothing to send
    run_cmd(1, 0, 2'd1, 16'h00A7, 7'd3, 8'h20, 0);   // R5 MSB read
    run_cmd(1, 1, 2'd2, 16'h81FE, 7'd2, 8'h01, 0);   // R5 R2 LSB read
    run_cmd(1, 0, 2'd0, 16'h0000, 7'd1, 8'h03, 0);   // R7 two selects on read
    run_cmd(1, 0, 2'd0, 16'h0000, 7'd1, 8'h00, 0);   // R7 no select on read
    run_cmd(0, 0, 2'd0, 16'h0000, 7'd65, 8'h01, 0);  // R8 body too long
    run_cmd(0, 0, 2'b11, 16'h1234, 7'd1, 8'h01, 0);  // R8 bad prefix code
    run_cmd(0, 0, 2'd1, 16'h0F0F, 7'd2, 8'h08, 1);   // R10 start while busy
    fill(13);
    run_cmd(0, 1, 2'd0, 16'h0000, 7'd64, 8'hFF, 0);  // R4 R8 longest legal body
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule